// File: doc/BRIEF.md
# Per-Bit Enabled Domain Control Register

This block is a single memory-mapped control word whose writes carry their own bit-level enables. In the bus word, the upper half acts as an enable mask and the lower half holds the new values. Only the control bits whose enable is set take the matching data bit. Every other bit keeps its value. Software can therefore set or clear one domain's bit in a single write, with no read-modify-write and no race against other agents writing the same register.

Each control bit belongs to one power domain. The register can be used in two ways. When it serves as a power switch bank, a 1 turns the domain off and a 0 keeps it powered. When it serves as an idle-request bank, a 1 asks the domain's interconnect port to go idle. The bits drive a parallel output directly. They can be read back over the same simple bus one cycle after the address is presented.

Top module: `wmask_ctrl_reg`

## Requirements
- R1: While the synchronous reset is high at a clock edge, all control bits and the read data become 0. This means every domain is powered with no idle request, and reset wins over a simultaneous write.
- R2: On a write to the register address, a control bit n whose enable bit (bus bit n+16) and data bit (bus bit n) are both 1 becomes 1 after that clock edge.
- R3: On a write to the register address, a control bit n whose enable bit is 1 and whose data bit is 0 becomes 0 after that clock edge.
- R4: On a write to the register address, a control bit whose enable bit is 0 keeps its value, whatever its data bit holds.
- R5: A write to any other address leaves every control bit unchanged.
- R6: When the write strobe is low, no control bit changes, even at the register address.
- R7: Reads take one cycle. When the register address is presented at a clock edge, the read data after that edge holds the control bits in [15:0] and zeros in [31:16]. Any other address reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write word: [31:16] enables, [15:0] values |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| ctrl_out | output | 16 | Control bits, one per domain (1 = off or idle request) |

## Verification
The hardest case to reach from the ports is a single write that sets some bits, clears others and holds the rest, applied to a register that already has a mixed pattern. Only then does a swapped or dropped enable show up in the output. The stimulus table first builds up distinct patterns through single-bit and byte-wide writes. It then applies words whose enable and data halves disagree in many positions. A reset is also driven in the same cycle as a full-enable write, to show that reset takes priority.

// File: rtl/wmask_pkg.sv
package wmask_pkg;

  localparam int unsigned WM_BUS_W   = 32;
  localparam int unsigned WM_ADDR_W  = 8;
  localparam int unsigned WM_NUM_CTL = 16;

  // Selects the new value of one control bit from its enable and data.
  function automatic logic merge_bit(input logic old_v, input logic en, input logic val);
    return en ? val : old_v;
  endfunction

endpackage

// File: rtl/wmask_decode.sv
module wmask_decode #(
  parameter int unsigned ADDR_W   = wmask_pkg::WM_ADDR_W,
  parameter int unsigned DATA_W   = wmask_pkg::WM_BUS_W,
  parameter int unsigned NUM_CTRL = wmask_pkg::WM_NUM_CTL,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                we,
  output logic [NUM_CTRL-1:0] bit_en,
  output logic [NUM_CTRL-1:0] bit_val,
  output logic                rd_sel
);
  localparam int unsigned HALF = DATA_W / 2;

  logic wr_hit;

  always_comb begin
    rd_sel = (addr == REG_ADDR);
    wr_hit = we & rd_sel;
  end

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_lane
    always_comb begin
      bit_en[i]  = wr_hit & wdata[HALF + i];
      bit_val[i] = wdata[i];
    end
  end

endmodule

// File: rtl/wmask_bit_cell.sv
module wmask_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  logic upd_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= wmask_pkg::merge_bit(q, upd_en, upd_val);
  end
endmodule

// File: rtl/wmask_readback.sv
module wmask_readback #(
  parameter int unsigned DATA_W   = wmask_pkg::WM_BUS_W,
  parameter int unsigned NUM_CTRL = wmask_pkg::WM_NUM_CTL
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_sel,
  input  logic [NUM_CTRL-1:0] ctrl,
  output logic [DATA_W-1:0]   rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_sel) rdata <= DATA_W'(ctrl);
    else             rdata <= '0;
  end
endmodule

// File: rtl/wmask_ctrl_reg.sv
module wmask_ctrl_reg #(
  parameter int unsigned ADDR_W   = wmask_pkg::WM_ADDR_W,
  parameter int unsigned DATA_W   = wmask_pkg::WM_BUS_W,
  parameter int unsigned NUM_CTRL = wmask_pkg::WM_NUM_CTL,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CTRL-1:0] ctrl_out
);
  logic [NUM_CTRL-1:0] bit_en;
  logic [NUM_CTRL-1:0] bit_val;
  logic                rd_sel;

  wmask_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .REG_ADDR(REG_ADDR)
  ) dec_i (
    .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .bit_en(bit_en), .bit_val(bit_val), .rd_sel(rd_sel)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_cell
    wmask_bit_cell cell_i (
      .clk(clk), .rst(rst), .upd_en(bit_en[i]), .upd_val(bit_val[i]), .q(ctrl_out[i])
    );
  end

  wmask_readback #(.DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)) rb_i (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .ctrl(ctrl_out), .rdata(bus_rdata)
  );

endmodule

// File: rtl/wmask_ctrl_reg_chk.sv
module wmask_ctrl_reg_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CTRL = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_CTRL-1:0] ctrl_out
);
  localparam int unsigned HALF = DATA_W / 2;

  logic                hit_w;
  logic [NUM_CTRL-1:0] en_w;
  logic [NUM_CTRL-1:0] dv_w;

  always_comb begin
    hit_w = bus_we && (bus_addr == REG_ADDR);
    en_w  = bus_wdata[HALF +: NUM_CTRL];
    dv_w  = bus_wdata[NUM_CTRL-1:0];
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> ((ctrl_out & $past(en_w & dv_w)) == $past(en_w & dv_w)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> ((ctrl_out & $past(en_w & ~dv_w)) == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> (((ctrl_out ^ $past(ctrl_out)) & ~$past(en_w)) == '0));

  p_no_write_r5_r6: assert property (@(posedge clk) disable iff (rst)
    !hit_w |=> $stable(ctrl_out));

  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_ADDR) |=> (bus_rdata == DATA_W'($past(ctrl_out))));

  p_other_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != REG_ADDR) |=> (bus_rdata == '0));

endmodule

bind wmask_ctrl_reg wmask_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .REG_ADDR(REG_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .ctrl_out(ctrl_out)
);

// File: tb/wmask_ctrl_reg_tb_top.sv
`timescale 1ns/100ps
module wmask_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [15:0] ctrl_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  wmask_ctrl_reg dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ctrl_out(ctrl_out)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic        w;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 32'h0001_0001, 1'b1, 16'h0001, 4'd2},  // R2 single bit set
    '{8'h10, 32'h8000_8000, 1'b1, 16'h8001, 4'd2},  // R2 top bit set
    '{8'h10, 32'h0000_FFFF, 1'b1, 16'h8001, 4'd4},  // R4 data without enables
    '{8'h10, 32'h0001_0000, 1'b1, 16'h8000, 4'd3},  // R3 single bit clear
    '{8'h14, 32'hFFFF_FFFF, 1'b1, 16'h8000, 4'd5},  // R5 other address
    '{8'h10, 32'hFFFF_FFFF, 1'b0, 16'h8000, 4'd6},  // R6 strobe low
    '{8'h10, 32'h00FF_00AA, 1'b1, 16'h80AA, 4'd4},  // R4 mixed low byte
    '{8'h10, 32'hFF00_5500, 1'b1, 16'h55AA, 4'd3},  // R3 mixed high byte
    '{8'h10, 32'hFFFF_0000, 1'b1, 16'h0000, 4'd3},  // R3 clear all
    '{8'h10, 32'hFFFF_FFFF, 1'b1, 16'hFFFF, 4'd2},  // R2 set all
    '{8'h10, 32'h0F0F_0000, 1'b1, 16'hF0F0, 4'd3},  // R3 nibble clears
    '{8'h00, 32'hFFFF_0000, 1'b1, 16'hF0F0, 4'd5}   // R5 address zero
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; bus_addr = 8'h00; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check32("R1", {16'h0, ctrl_out}, 32'h0);
    check32("R1", bus_rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      bus_addr = VECS[i].a; bus_wdata = VECS[i].d; bus_we = VECS[i].w;
      @(negedge clk);
      bus_we = 1'b0;
      check32($sformatf("R%0d", VECS[i].req), {16'h0, ctrl_out}, {16'h0, VECS[i].exp});
    end

    // R7 readback of register address
    bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
    @(negedge clk);
    check32("R7", bus_rdata, 32'h0000_F0F0);
    // R7 other address reads zero
    bus_addr = 8'h14;
    @(negedge clk);
    check32("R7", bus_rdata, 32'h0);

    // R7 read during write shows pre-write value
    bus_addr = 8'h10; bus_wdata = 32'hFFFF_0001; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check32("R7", bus_rdata, 32'h0000_F0F0);
    check32("R2", {16'h0, ctrl_out}, 32'h0000_0001);

    // R1 reset wins over simultaneous full-enable write
    bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1; rst = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; rst = 1'b0;
    check32("R1", {16'h0, ctrl_out}, 32'h0);
    check32("R1", bus_rdata, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule